// File: doc/BRIEF.md
# Power Rail Fault Supervisor

This block is the digital fault manager for a supply with four rails. Rail 1 is a switching converter and rails 2 to 4 are linear regulators. Two soft-start ramps drive the start-up. Ramp A serves rails 1 and 3, and ramp B serves rails 2 and 4. Analog comparators outside the block turn rail overvoltage, overcurrent, undervoltage and the ramp thresholds into single-bit flags. The block brings each flag into its clock domain through a synchronizer, decides how severe each event is, and drives a shared inhibit for rails 1 to 3, a request to discharge ramp B, a one-cycle restart strobe and a latched-off flag.

There are two classes of fault. A rail-1 overvoltage or a rail-4 undervoltage shuts the supply down for good. A rail-1 overcurrent or a rail-2 or rail-3 undervoltage starts a retry instead. The retry inhibits the rails, discharges ramp B and restarts once ramp B reports that it is empty. Each retry class has its own saturating counter. The third consecutive event in either class shuts the supply down for good. A clean start-up clears both counters, and only the power-on reset leaves the shut-down state.

Top module: `rail_fault_supervisor`

## Requirements
- R1: A rising overvoltage flag on rail 1 moves the block to the latched-off state in any state, whatever the ramp flags are. Latched-off means `latchedOff`=1 and `inhibitRails`=1.
- R2: A rail-4 undervoltage while `rampBDone`=1 moves the block to latched-off. Neither counter changes.
- R3: A rising rail-1 overcurrent flag in normal operation adds one to `ocCount`. It also raises `inhibitRails` and `dischargeReq`.
- R4: A rail-2 undervoltage while `rampBDone`=1, or a rail-3 undervoltage while `rampADone`=1, adds one to `uvCount`. It also raises `inhibitRails` and `dischargeReq`.
- R5: The event that brings either counter to 3 moves the block to latched-off. A counter never exceeds 3.
- R6: In normal operation, with both `rampADone` and `rampBDone` high and no fault edge, both counters clear to 0.
- R7: Undervoltage on rails 2 and 4 is ignored while `rampBDone`=0. Undervoltage on rail 3 is ignored while `rampADone`=0. A masked flag that is still high when its ramp completes counts as a new event at that moment.
- R8: During a retry, `rampBLow`=1 drops `inhibitRails` and `dischargeReq` and produces exactly one single-cycle `restartReq` pulse.
- R9: A fault flag that stays high is acted on once. It must fall and rise again before it counts again.
- R10: `porN`=0 clears the latched-off state and both counters. Latched-off persists until that reset. After reset all outputs are 0.
- R11: Each input passes through a two-flop synchronizer. Its effect shows at the outputs on the third rising clock edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| ovRail1 | input | 1 | Rail 1 overvoltage flag |
| ocRail1 | input | 1 | Rail 1 overcurrent flag |
| uvRail2 | input | 1 | Rail 2 undervoltage flag |
| uvRail3 | input | 1 | Rail 3 undervoltage flag |
| uvRail4 | input | 1 | Rail 4 undervoltage flag |
| rampADone | input | 1 | Ramp A (rails 1 and 3) has reached its top threshold |
| rampBDone | input | 1 | Ramp B (rails 2 and 4) has reached its top threshold |
| rampBLow | input | 1 | Ramp B is below its discharged threshold |
| inhibitRails | output | 1 | Disable rails 1 to 3 |
| dischargeReq | output | 1 | Request to discharge ramp B (retry pending) |
| restartReq | output | 1 | One-cycle strobe that starts a soft-start ramp |
| latchedOff | output | 1 | Permanent shut-down until power-on reset |
| ocCount | output | 2 | Consecutive rail-1 overcurrent count |
| uvCount | output | 2 | Consecutive rail-2 and rail-3 undervoltage count |

## Verification
A wrong edge register or a wrong mask shows up as a counter step that is missing or doubled. The fault-to-output latency is three edges, so the count is wrong three edges after the flag moves. A wrong state is visible at once as a wrong combination of `inhibitRails`, `dischargeReq` and `latchedOff`. A counter that fails to clear is hidden until a later retry sequence reaches latched-off early, so the bench runs a full clear-and-refill sequence.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_RETRY = 2'd1,
    ST_OFF   = 2'd2
  } supState_e;

  // control -> datapath
  typedef struct packed {
    logic incOc;
    logic incUv;
    logic clrCounts;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic ovHit;
    logic ocHit;
    logic uvLinHit;
    logic uv4Hit;
    logic bothDone;
    logic rampBLow;
  } dpFlags_t;

endpackage

// File: rtl/fsv_sync.sv
module fsv_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/fsv_datapath.sv
module fsv_datapath
  import fsv_pkg::*;
#(
  parameter int RETRY_LIMIT = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ovRail1,
  input  logic             ocRail1,
  input  logic             uvRail2,
  input  logic             uvRail3,
  input  logic             uvRail4,
  input  logic             rampADone,
  input  logic             rampBDone,
  input  logic             rampBLow,
  input  dpStrobe_t        strobe,
  output dpFlags_t         flags,
  output logic [CNT_W-1:0] ocCount,
  output logic [CNT_W-1:0] uvCount
);

  localparam int NUM_IN  = 8;
  localparam int NUM_LVL = 5;
  localparam int NUM_CNT = 2;

  logic [NUM_IN-1:0] rawIn, syncIn;
  assign rawIn = {ovRail1, ocRail1, uvRail2, uvRail3, uvRail4,
                  rampADone, rampBDone, rampBLow};

  fsv_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncIn)
  );

  logic sOv, sOc, sUv2, sUv3, sUv4, sDoneA, sDoneB, sLowB;
  assign {sOv, sOc, sUv2, sUv3, sUv4, sDoneA, sDoneB, sLowB} = syncIn;

  // qualified fault levels: linear undervoltage masked by its ramp
  logic [NUM_LVL-1:0] lvl, lvlPrev, hit;
  assign lvl = {sOv, sOc, sUv2 & sDoneB, sUv3 & sDoneA, sUv4 & sDoneB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '0;
    else       lvlPrev <= lvl;
  end

  assign hit = lvl & ~lvlPrev;

  assign flags.ovHit    = hit[4];
  assign flags.ocHit    = hit[3];
  assign flags.uvLinHit = hit[2] | hit[1];
  assign flags.uv4Hit   = hit[0];
  assign flags.bothDone = sDoneA & sDoneB;
  assign flags.rampBLow = sLowB;

  // retry counters: index 0 = overcurrent, 1 = linear undervoltage
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic [NUM_CNT-1:0] incVec;
  assign incVec = {strobe.incUv, strobe.incOc};

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt[c] <= '0;
      else if (strobe.clrCounts)
        cnt[c] <= '0;
      else if (incVec[c] && (cnt[c] < CNT_W'(RETRY_LIMIT)))
        cnt[c] <= cnt[c] + 1'b1;
    end
  end

  assign ocCount = cnt[0];
  assign uvCount = cnt[1];

  // R5: counters saturate at the limit
  p_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ocCount <= CNT_W'(RETRY_LIMIT)) && (uvCount <= CNT_W'(RETRY_LIMIT)));

  // R3: overcurrent count only steps by one or clears
  p_oc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ocCount != $past(ocCount)) |->
      ((ocCount == CNT_W'($past(ocCount) + 1'b1)) || (ocCount == '0)));

  // R4: undervoltage count only steps by one or clears
  p_uv_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (uvCount != $past(uvCount)) |->
      ((uvCount == CNT_W'($past(uvCount) + 1'b1)) || (uvCount == '0)));

endmodule

// File: rtl/fsv_control.sv
module fsv_control
  import fsv_pkg::*;
#(
  parameter int RETRY_LIMIT = 3,
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpFlags_t         flags,
  input  logic [CNT_W-1:0] ocCount,
  input  logic [CNT_W-1:0] uvCount,
  output dpStrobe_t        strobe,
  output logic             inhibitRails,
  output logic             dischargeReq,
  output logic             restartReq,
  output logic             latchedOff
);

  localparam logic [CNT_W-1:0] LAST_RETRY = CNT_W'(RETRY_LIMIT - 1);

  supState_e state, stateNext;
  logic restartNext;
  logic fatalHit, retryHit, retryExhausted;

  assign fatalHit = flags.ovHit | flags.uv4Hit;
  assign retryHit = flags.ocHit | flags.uvLinHit;
  assign retryExhausted = (flags.ocHit && ocCount == LAST_RETRY) ||
                          (flags.uvLinHit && uvCount == LAST_RETRY);

  always_comb begin
    stateNext   = state;
    restartNext = 1'b0;
    strobe      = '0;
    unique case (state)
      ST_RUN: begin
        if (fatalHit) begin
          stateNext = ST_OFF;
        end else if (retryHit) begin
          strobe.incOc = flags.ocHit;
          strobe.incUv = flags.uvLinHit;
          stateNext    = retryExhausted ? ST_OFF : ST_RETRY;
        end else if (flags.bothDone) begin
          strobe.clrCounts = 1'b1;
        end
      end
      ST_RETRY: begin
        if (fatalHit) begin
          stateNext = ST_OFF;
        end else if (flags.rampBLow) begin
          stateNext   = ST_RUN;
          restartNext = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      restartReq <= 1'b0;
    end else begin
      state      <= stateNext;
      restartReq <= restartNext;
    end
  end

  assign inhibitRails = (state != ST_RUN);
  assign dischargeReq = (state == ST_RETRY);
  assign latchedOff   = (state == ST_OFF);

  // R1: overvoltage edge always shuts down
  p_ov_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    flags.ovHit |=> latchedOff);

  // R2: rail-4 undervoltage edge always shuts down
  p_uv4_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    flags.uv4Hit |=> latchedOff);

  // R10: latched-off persists and keeps rails inhibited
  p_off_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    latchedOff |=> (latchedOff && inhibitRails));

  // R8: empty ramp B ends a retry with a restart strobe
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dischargeReq && flags.rampBLow && !fatalHit) |=> (!inhibitRails && restartReq));

  // R8: restart strobe lasts one cycle
  p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);

endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
  import fsv_pkg::*;
#(
  parameter int RETRY_LIMIT = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             ovRail1,
  input  logic             ocRail1,
  input  logic             uvRail2,
  input  logic             uvRail3,
  input  logic             uvRail4,
  input  logic             rampADone,
  input  logic             rampBDone,
  input  logic             rampBLow,
  output logic             inhibitRails,
  output logic             dischargeReq,
  output logic             restartReq,
  output logic             latchedOff,
  output logic [CNT_W-1:0] ocCount,
  output logic [CNT_W-1:0] uvCount
);

  dpStrobe_t strobe;
  dpFlags_t  flags;

  fsv_datapath #(.RETRY_LIMIT(RETRY_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (porN),
    .ovRail1  (ovRail1),
    .ocRail1  (ocRail1),
    .uvRail2  (uvRail2),
    .uvRail3  (uvRail3),
    .uvRail4  (uvRail4),
    .rampADone(rampADone),
    .rampBDone(rampBDone),
    .rampBLow (rampBLow),
    .strobe   (strobe),
    .flags    (flags),
    .ocCount  (ocCount),
    .uvCount  (uvCount)
  );

  fsv_control #(.RETRY_LIMIT(RETRY_LIMIT)) u_ctl (
    .clk         (clk),
    .rstN        (porN),
    .flags       (flags),
    .ocCount     (ocCount),
    .uvCount     (uvCount),
    .strobe      (strobe),
    .inhibitRails(inhibitRails),
    .dischargeReq(dischargeReq),
    .restartReq  (restartReq),
    .latchedOff  (latchedOff)
  );

endmodule

// File: tb/tb_rail_fault_supervisor.sv
module tb_rail_fault_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;
  localparam int NROWS      = 15;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic ovRail1 = 0, ocRail1 = 0, uvRail2 = 0, uvRail3 = 0, uvRail4 = 0;
  logic rampADone = 0, rampBDone = 0, rampBLow = 0;
  logic inhibitRails, dischargeReq, restartReq, latchedOff;
  logic [1:0] ocCount, uvCount;

  int checks = 0;
  int failures = 0;
  int restarts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_supervisor dut (
    .clk(clk), .porN(porN),
    .ovRail1(ovRail1), .ocRail1(ocRail1), .uvRail2(uvRail2),
    .uvRail3(uvRail3), .uvRail4(uvRail4),
    .rampADone(rampADone), .rampBDone(rampBDone), .rampBLow(rampBLow),
    .inhibitRails(inhibitRails), .dischargeReq(dischargeReq),
    .restartReq(restartReq), .latchedOff(latchedOff),
    .ocCount(ocCount), .uvCount(uvCount)
  );

  always @(negedge clk) if (porN && restartReq) restarts++;

  // row: {ov,oc,uv2,uv3,uv4,doneA,doneB,lowB} , {inh,dis,off,oc[1:0],uv[1:0]}
  localparam logic [14:0] TABLE [NROWS] = '{
    {8'b0000_0110, 7'b000_00_00}, // R6 idle, ramps up
    {8'b0100_0110, 7'b110_01_00}, // R3 overcurrent
    {8'b0000_0001, 7'b000_01_00}, // R8 ramp B empty -> restart
    {8'b0000_0000, 7'b000_01_00}, // ramping
    {8'b0001_0000, 7'b000_01_00}, // R7 uv3 masked
    {8'b0001_0100, 7'b110_01_01}, // R7 R4 mask lifts -> counts
    {8'b0000_0001, 7'b000_01_01}, // R8 restart
    {8'b0000_0110, 7'b000_00_00}, // R6 clean start clears
    {8'b0100_0000, 7'b110_01_00}, // R3 first
    {8'b0000_0001, 7'b000_01_00},
    {8'b0100_0000, 7'b110_10_00}, // R3 second
    {8'b0000_0001, 7'b000_10_00},
    {8'b0100_0000, 7'b101_11_00}, // R5 third -> off
    {8'b0000_0001, 7'b101_11_00}, // R10 off is sticky
    {8'b0000_0111, 7'b101_11_00}  // R10 still off
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    {ovRail1, ocRail1, uvRail2, uvRail3, uvRail4, rampADone, rampBDone, rampBLow} = v;
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkOut(input string req, input logic [6:0] e);
    chk(req, {inhibitRails, dischargeReq, latchedOff, ocCount, uvCount}, e);
  endtask

  task automatic doReset();
    @(negedge clk);
    {ovRail1, ocRail1, uvRail2, uvRail3, uvRail4, rampADone, rampBDone, rampBLow} = '0;
    porN = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0;
    doReset();
    chkOut("R10 reset state", 7'b000_00_00);
    chk("R10 reset restart", restartReq, 0);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      drive(TABLE[i][14:7]);
      chkOut($sformatf("table row %0d", i), TABLE[i][6:0]);
      if (i == 2) chk("R8 one restart pulse", restarts, 1);
      if (i == 6) chk("R8 second restart pulse", restarts, 2);
    end

    // R10: reset leaves latched-off
    doReset();
    chkOut("R10 reset clears off", 7'b000_00_00);

    // R1: overvoltage with ramps down
    drive(8'b1000_0000);
    chkOut("R1 overvoltage shuts down", 7'b101_00_00);
    drive(8'b0000_0001);
    chkOut("R1 R10 stays off", 7'b101_00_00);

    // R1 during retry
    doReset();
    drive(8'b0100_0000);
    drive(8'b1100_0000);
    chkOut("R1 overvoltage during retry", 7'b101_01_00);

    // R2 / R7 rail 4
    doReset();
    drive(8'b0000_1000);
    chkOut("R7 uv4 masked while ramp B low", 7'b000_00_00);
    drive(8'b0000_1010);
    chkOut("R2 uv4 latches off", 7'b101_00_00);

    // R4 / R7 rail 2
    doReset();
    drive(8'b0010_0100);
    chkOut("R7 uv2 masked by ramp B", 7'b000_00_00);
    drive(8'b0010_0010);
    chkOut("R4 uv2 counts", 7'b110_00_01);

    // R9: held overcurrent counts once
    doReset();
    drive(8'b0100_0000);
    chkOut("R9 first edge", 7'b110_01_00);
    r0 = restarts;
    drive(8'b0100_0001);
    drive(8'b0100_0000);
    chkOut("R9 held flag ignored", 7'b000_01_00);
    chk("R8 release pulse", restarts - r0, 1);

    // R5 undervoltage counter to limit
    doReset();
    for (int k = 0; k < 3; k++) begin
      drive(8'b0001_0100);
      if (k < 2) begin
        chk("R5 uv count", uvCount, k + 1);
        drive(8'b0000_0001);
      end
    end
    chkOut("R5 uv third -> off", 7'b101_00_11);

    // R11: latency of three edges
    doReset();
    @(negedge clk);
    ocRail1 = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 no effect after two edges", inhibitRails, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 effect on third edge", inhibitRails, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule